// File: doc/BRIEF.md
# Constant Reciprocal Divider (by 25 or by 24)

This block divides an unsigned 8-bit operand by one of two constant divisors, 25 or 24, picked by a select input. It has no iterative or array divider. Each divisor is replaced by a fixed-point reciprocal with a power-of-two denominator. 1/25 becomes 41/1024 and 1/24 becomes 85/2048. The multiply by each numerator is a short chain of hardwired shifts and adders. The product is then cut at a fixed bit position to give an integer quotient and a few fraction bits.

Both reciprocal products are formed in the same cycle from the input port. The select bit picks one of them, and the result is captured in output registers one clock after the input is marked valid. While no valid input arrives, the outputs keep their last value. A parameter can tie the fraction output to zero when a user needs only the integer part.

Top module: `recip_div`

## Requirements
- R1: With in_sel = 0 (divide by 25), out_quot equals floor(41·x / 1024).
- R2: With in_sel = 1 (divide by 24), out_quot equals floor(85·x / 2048). For the same x this result is never below the divide-by-25 result.
- R3: No intermediate sum wraps for any 8-bit x. At x = 255 both divisors give quotient 10, and no quotient ever exceeds 10.
- R4: out_frac carries the 5 bits just below the binary point of the scaled product. These are bits 9..5 of 41·x when in_sel = 0, and bits 10..6 of 85·x when in_sel = 1.
- R5: out_valid is high in exactly the cycle after each cycle with in_valid high. The result of that input appears in the same cycle.
- R6: While in_valid is low, out_quot and out_frac keep their previous values.
- R7: After reset, and until the first valid input, out_valid, out_quot and out_frac are all zero.
- R8: The divide-by-25 quotient equals floor(x/25) for every x. The divide-by-24 quotient equals floor(x/24) except at the ten nonzero multiples of 24 up to 240, where it is exactly one less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is valid this cycle |
| in_x | input | 8 | Unsigned dividend |
| in_sel | input | 1 | Divisor select: 0 divides by 25, 1 divides by 24 |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_quot | output | 4 | Truncated integer quotient |
| out_frac | output | 5 | Fraction bits below the binary point (zero when disabled) |

## Verification
Every cycle, the embedded properties check that the shift-add sums never wrap, that the divide-by-24 product never falls below the divide-by-25 product, and that the quotient stays within its bound. They also check the one-cycle valid timing, that the outputs hold while idle, and that the fraction stays zero when it is disabled. Only the bench scenarios can show that each quotient and fraction has the right value for every one of the 512 operand/divisor pairs. The same goes for the exact set of operands where the reciprocal approximation loses a count against true division, and for the reset state seen at the ports.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

   typedef enum logic {
      SEL_DIV25 = 1'b0,
      SEL_DIV24 = 1'b1
   } div_sel_e;

   // reciprocal numerators and denominator exponents
   localparam int unsigned NUM25 = 41;
   localparam int unsigned EXP25 = 10;
   localparam int unsigned NUM24 = 85;
   localparam int unsigned EXP24 = 11;

   // headroom bits needed above the operand for each numerator
   localparam int unsigned HEAD25 = $clog2(NUM25 + 1);
   localparam int unsigned HEAD24 = $clog2(NUM24 + 1);

   // quotient width for an operand of width w
   function automatic int unsigned quot_width(input int unsigned w);
      return w - 4;
   endfunction

endpackage

// File: rtl/mul41_path.sv
module mul41_path #(
   parameter int unsigned X_W = 8,
   parameter int unsigned P_W = X_W + 6
) (
   input  logic [X_W-1:0] x,
   output logic [P_W-1:0] prod
);

   if (P_W < X_W + 6) begin : g_chk_w
      $error("mul41_path: product width too small");
   end

   logic [P_W-1:0] term_hi;
   logic [P_W-1:0] term_mid;
   logic [P_W-1:0] term_lo;

   // 41x = 32x + 8x + x; the single x term rides in as a third operand
   always_comb begin
      term_hi  = P_W'(x) << 5;
      term_mid = P_W'(x) << 3;
      term_lo  = P_W'(x);
      prod     = term_hi + term_mid + term_lo;
   end

   always_comb begin
      if (!$isunknown(x)) begin
         AST_NO_OVERFLOW_41: assert (prod >= term_hi && prod >= term_mid); // R3
      end
   end

endmodule

// File: rtl/mul85_path.sv
module mul85_path #(
   parameter int unsigned X_W = 8,
   parameter int unsigned P_W = X_W + 7
) (
   input  logic [X_W-1:0] x,
   output logic [P_W-1:0] prod
);

   localparam int unsigned M5_W = X_W + 3;

   if (P_W < X_W + 7) begin : g_chk_w
      $error("mul85_path: product width too small");
   end

   logic [M5_W-1:0] times5;
   logic [P_W-1:0]  times80;

   // 5x = x + 4x, then 85x = 5x + 16*5x
   always_comb begin
      times5  = M5_W'(x) + (M5_W'(x) << 2);
      times80 = P_W'(times5) << 4;
      prod    = P_W'(times5) + times80;
   end

   always_comb begin
      if (!$isunknown(x)) begin
         AST_NO_OVERFLOW_5: assert (times5 >= M5_W'(x)); // R3
         AST_NO_OVERFLOW_85: assert (prod >= times80); // R3
      end
   end

endmodule

// File: rtl/fix_split.sv
module fix_split #(
   parameter int unsigned P_W     = 14,
   parameter int unsigned SH      = 10,
   parameter int unsigned Q_W     = 4,
   parameter int unsigned FRAC_W  = 5,
   parameter bit          FRAC_EN = 1'b1
) (
   input  logic [P_W-1:0]    prod,
   output logic [Q_W-1:0]    quot,
   output logic [FRAC_W-1:0] frac
);

   if (P_W - SH > Q_W) begin : g_chk_q
      $error("fix_split: quotient width drops product bits");
   end
   if (FRAC_W > SH) begin : g_chk_f
      $error("fix_split: more fraction bits than shift");
   end

   // truncation: bits below the point are simply not carried into quot
   assign quot = Q_W'(prod >> SH);

   if (FRAC_EN) begin : g_frac
      assign frac = prod[SH-1 -: FRAC_W];
   end else begin : g_nofrac
      assign frac = '0;
   end

endmodule

// File: rtl/recip_div.sv
module recip_div
   import recip_div_pkg::*;
#(
   parameter int unsigned X_W     = 8,
   parameter int unsigned FRAC_W  = 5,
   parameter bit          FRAC_EN = 1'b1,
   localparam int unsigned Q_W    = X_W - 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [X_W-1:0]    in_x,
   input  logic              in_sel,
   output logic              out_valid,
   output logic [Q_W-1:0]    out_quot,
   output logic [FRAC_W-1:0] out_frac
);

   localparam int unsigned P25_W = X_W + HEAD25;
   localparam int unsigned P24_W = X_W + HEAD24;
   localparam int unsigned X_MAX = (1 << X_W) - 1;
   localparam int unsigned Q_MAX = (X_MAX * NUM24) >> EXP24;

   if (X_W < 5 || X_W > 16) begin : g_chk_x
      $error("recip_div: operand width out of range");
   end
   if (Q_W != quot_width(X_W)) begin : g_chk_q
      $error("recip_div: quotient width mismatch");
   end
   if (FRAC_W < 1 || FRAC_W > EXP25) begin : g_chk_f
      $error("recip_div: fraction width out of range");
   end

   logic [P25_W-1:0]  prod25;
   logic [P24_W-1:0]  prod24;
   logic [Q_W-1:0]    q25, q24, q_sel;
   logic [FRAC_W-1:0] f25, f24, f_sel;

   mul41_path #(.X_W(X_W), .P_W(P25_W)) i_mul41 (
      .x    (in_x),
      .prod (prod25)
   );

   mul85_path #(.X_W(X_W), .P_W(P24_W)) i_mul85 (
      .x    (in_x),
      .prod (prod24)
   );

   fix_split #(
      .P_W(P25_W), .SH(EXP25), .Q_W(Q_W), .FRAC_W(FRAC_W), .FRAC_EN(FRAC_EN)
   ) i_split25 (
      .prod (prod25),
      .quot (q25),
      .frac (f25)
   );

   fix_split #(
      .P_W(P24_W), .SH(EXP24), .Q_W(Q_W), .FRAC_W(FRAC_W), .FRAC_EN(FRAC_EN)
   ) i_split24 (
      .prod (prod24),
      .quot (q24),
      .frac (f24)
   );

   always_comb begin
      if (div_sel_e'(in_sel) == SEL_DIV24) begin
         q_sel = q24;
         f_sel = f24;
      end else begin
         q_sel = q25;
         f_sel = f25;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_quot  <= '0;
         out_frac  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_quot <= q_sel;
            out_frac <= f_sel;
         end
      end
   end

   // the 85/2048 scale exceeds 41/1024, so its product can never be smaller
   always_comb begin
      if (!$isunknown(in_x)) begin
         AST_DIV24_NOT_BELOW: assert (prod24 >= P24_W'(prod25)); // R2
      end
   end

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R5
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R5
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_quot) && $stable(out_frac))); // R6
   AST_QUOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_quot <= Q_W'(Q_MAX))); // R3

   if (!FRAC_EN) begin : g_frac_off_chk
      AST_FRAC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         out_frac == '0); // R4
   end

endmodule

// File: tb/test_recip_div.sv
module test_recip_div;

   localparam int X_W = 8;
   localparam int Q_W = 4;
   localparam int F_W = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [X_W-1:0] in_x = '0;
   logic           in_sel = 1'b0;
   logic           out_valid;
   logic [Q_W-1:0] out_quot;
   logic [F_W-1:0] out_frac;

   int checks = 0;
   int errors = 0;
   int mis24 = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [X_W-1:0] x;
      logic           sel;
   } item_t;

   item_t sb_q[$];
   int last_q = 0;
   int last_f = 0;

   always #2 clk = ~clk;

   recip_div i_recip_div (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
      .in_sel(in_sel), .out_valid(out_valid), .out_quot(out_quot),
      .out_frac(out_frac)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input int x, input bit sel);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      in_x = X_W'(x);
      in_sel = sel;
      it.x = X_W'(x);
      it.sel = sel;
      sb_q.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_x = X_W'(8'hA5 + i);
         in_sel = i[0];
      end
   endtask

   // monitor: samples 1 time unit after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && !done) begin
            // R5: output valid follows the input valid of the previous edge
            chk(out_valid == in_valid, "R5 valid timing", out_valid, in_valid);
            if (out_valid && sb_q.size() > 0) begin
               item_t it;
               int p, eq, ef, ex;
               it = sb_q.pop_front();
               if (it.sel) begin
                  p  = 85 * int'(it.x);
                  eq = p >> 11;
                  ef = (p >> 6) & 31;
                  ex = int'(it.x) / 24;
                  chk(out_quot == eq, "R2 div24 quotient", out_quot, eq);
                  if (eq != ex) begin
                     mis24++;
                     chk((int'(it.x) % 24 == 0) && (eq == ex - 1),
                         "R8 div24 mismatch position", eq, ex);
                  end
               end else begin
                  p  = 41 * int'(it.x);
                  eq = p >> 10;
                  ef = (p >> 5) & 31;
                  ex = int'(it.x) / 25;
                  chk(out_quot == eq, "R1 div25 quotient", out_quot, eq);
                  chk(eq == ex, "R8 div25 exact", out_quot, ex);
               end
               chk(out_frac == ef, "R4 fraction bits", out_frac, ef);
               last_q = eq;
               last_f = ef;
            end else if (!out_valid && sb_q.size() > 0 && !in_valid) begin
               // R6: idle outputs keep the last result
               chk(out_quot == last_q, "R6 quotient hold", out_quot, last_q);
               chk(out_frac == last_f, "R6 fraction hold", out_frac, last_f);
            end else if (!out_valid) begin
               chk(out_quot == last_q, "R6 quotient hold", out_quot, last_q);
               chk(out_frac == last_f, "R6 fraction hold", out_frac, last_f);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      chk(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
      chk(out_quot == '0, "R7 reset quotient", out_quot, 0);
      chk(out_frac == '0, "R7 reset fraction", out_frac, 0);
      rst_n = 1'b1;
      idle(3);
      chk(out_quot == '0, "R7 quotient after reset idle", out_quot, 0);

      // sweep for divide by 25, back to back
      for (int x = 0; x < 256; x++) drive(x, 1'b0);
      idle(4);
      // sweep for divide by 24 with gaps every 16 operands
      for (int x = 0; x < 256; x++) begin
         drive(x, 1'b1);
         if (x % 16 == 15) idle(2);
      end
      idle(2);
      // R3: top operand for both divisors, alternating
      drive(255, 1'b0);
      drive(255, 1'b1);
      drive(24, 1'b1);
      drive(25, 1'b0);
      idle(5);
      @(negedge clk);
      chk(out_quot == 4'd1 && sb_q.size() == 0, "R3 final quotient", out_quot, 1);
      // R8: ten multiples of 24 fall one short; 24 seen twice in the run
      chk(mis24 == 11, "R8 div24 mismatch count", mis24, 11);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule